// File: doc/BRIEF.md
# Conditional Program-Counter Redirect Unit

This unit works out the next value of the active 16-bit program counter for three kinds of control transfer: the short branch, which stays within the current 256-byte page; the long branch, which loads a full two-byte target; and the long skip, which steps over the two bytes that follow the opcode. The surrounding execute logic pulses `start` once. With that pulse it supplies the group select (short or long), the low opcode nibble, the current counter value and the condition sources. The condition sources are the output flip-flop, the accumulator, the carry flag, the interrupt-enable bit and four external flag pins, which are active-low.

The unit evaluates the condition in the cycle in which it accepts `start`. It then fetches only the immediate bytes it actually consumes, one read cycle per byte, through a simple memory port whose data returns in the same cycle. When it is finished it presents the new counter value and a `taken` indication together with a one-cycle `done` pulse. The external flags pass through a two-stage synchronizer before they are sampled.

Top module: `pc_redirect_unit`

## Requirements
- R1: After reset `done`, `rd_req` and `taken` are 0 and `pc_out` is 0.
- R2: A taken short branch makes one read at the current counter and produces {old high byte, byte read}, with `done` two cycles after the `start` edge.
- R3: A short branch that is not taken makes no read and produces counter+1, with `done` one cycle after the `start` edge.
- R4: The short conditions for nibble values 0 to 7 are: always, output flip-flop = 1, accumulator = 0, carry = 1, then external flags 1 to 4 asserted, where a flag is asserted when its pin is low (pin bit k carries flag k+1). Nibble bit 3 inverts the sense, so nibble 8 never branches.
- R5: A taken long branch reads the counter address and then counter+1, and loads {first byte, second byte}, with `done` three cycles after the `start` edge.
- R6: Long nibbles 0 to 3 branch on always, output flip-flop = 1, accumulator = 0 and carry = 1. Nibbles 9 to B branch on the inverse of nibbles 1 to 3. When not taken the result is counter+2 and no read is made.
- R7: Long nibble 4 leaves the counter unchanged and reports `taken` = 0. Nibbles 5, 6 and 7 skip on output flip-flop = 0, accumulator ≠ 0 and carry = 0. Nibble 8 always skips. Nibbles C to F skip on interrupt-enable = 1, output flip-flop = 1, accumulator = 0 and carry = 1. A skip yields counter+2, a non-skip yields the counter unchanged, and neither makes a read.
- R8: The external flag pins are synchronized through two stages. A pin change made in the same cycle as `start` is not seen by that operation.
- R9: `done` lasts one cycle. `taken` is valid with it, and `pc_out` holds its value until the next `done`.
- R10: A `start` that arrives while an operation is in progress is ignored. The running operation completes with its original inputs.
- R11: All counter arithmetic and read addresses wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept an operation (ignored while busy) |
| is_long | input | 1 | 1 = long group (branch/skip), 0 = short branch |
| nib | input | 4 | Low opcode nibble selecting the condition |
| pc_in | input | 16 | Current program-counter value |
| q_in | input | 1 | Output flip-flop state |
| d_in | input | 8 | Accumulator |
| df_in | input | 1 | Carry flag |
| ie_in | input | 1 | Interrupt-enable bit |
| ef_n | input | 4 | External flag pins, active-low, asynchronous |
| rd_data | input | 8 | Memory data for `rd_addr`, valid in the same cycle |
| rd_req | output | 1 | Immediate-byte read request |
| rd_addr | output | 16 | Read address |
| pc_out | output | 16 | New program-counter value |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch or skip performed |

## Verification
Two functions can meet in one cycle. The first is a new `start` arriving while immediate-byte reads are under way. The bench provokes this by holding `start` high with a different counter value for every cycle of a long branch, and it judges the case by checking that the read addresses and the final target still follow the original counter. The second is an external flag pin changing in the same cycle as `start`. There the bench expects the old synchronized level to decide the condition. A behavioural model predicts the read schedule, the result and the timing of `done` for every cycle.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int FLAG_N = 4;

  typedef enum logic [1:0] {K_SHORT, K_LBR, K_LSKP, K_NOP} op_kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RD_HI, ST_RD_LO, ST_FIN} seq_st_e;

  // Classify a long-group nibble.
  function automatic op_kind_e long_kind(input logic [3:0] n);
    case (n)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h9, 4'hA, 4'hB: return K_LBR;
      4'h4:                                     return K_NOP;
      default:                                  return K_LSKP;
    endcase
  endfunction
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[b] <= '1;
      else        chain[b] <= {chain[b][STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import pcr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              is_long,
  input  logic [3:0]        nib,
  input  logic              q_in,
  input  logic [DW-1:0]     d_in,
  input  logic              df_in,
  input  logic              ie_in,
  input  logic [FLAG_N-1:0] ef_seen_n,
  output op_kind_e          op_kind,
  output logic              cond_hit
);
  logic d_zero, base_cond, skip_cond;

  assign d_zero = (d_in == '0);

  // Shared base table for nibble[2:0]; flags are active-low.
  always_comb begin
    case (nib[2:0])
      3'd0:    base_cond = 1'b1;
      3'd1:    base_cond = q_in;
      3'd2:    base_cond = d_zero;
      3'd3:    base_cond = df_in;
      default: base_cond = ~ef_seen_n[nib[1:0]];
    endcase
  end

  always_comb begin
    case (nib)
      4'h5:    skip_cond = ~q_in;
      4'h6:    skip_cond = ~d_zero;
      4'h7:    skip_cond = ~df_in;
      4'hC:    skip_cond = ie_in;
      4'hD:    skip_cond = q_in;
      4'hE:    skip_cond = d_zero;
      4'hF:    skip_cond = df_in;
      default: skip_cond = 1'b1;
    endcase
  end

  always_comb begin
    op_kind = is_long ? long_kind(nib) : K_SHORT;
    case (op_kind)
      K_SHORT, K_LBR: cond_hit = base_cond ^ nib[3];
      K_LSKP:         cond_hit = skip_cond;
      default:        cond_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/redirect_seq.sv
module redirect_seq
  import pcr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_long,
  input  op_kind_e      op_kind,
  input  logic          cond_hit,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] rd_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] pc_out,
  output logic          done,
  output logic          taken
);
  localparam int HI_W = AW - DW;

  function automatic logic [AW-1:0] pc_add(input logic [AW-1:0] pc, input int unsigned inc);
    return pc + AW'(inc);
  endfunction

  seq_st_e       st;
  op_kind_e      kind_lat;
  logic [AW-1:0] pc_lat;
  logic [HI_W-1:0] hi_lat;
  logic          long_lat;
  logic          accept;

  assign accept = (st == ST_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      kind_lat <= K_NOP;
      pc_lat   <= '0;
      hi_lat   <= '0;
      long_lat <= 1'b0;
      pc_out   <= '0;
      taken    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          pc_lat   <= pc_in;
          long_lat <= is_long;
          kind_lat <= op_kind;
          taken    <= cond_hit && (op_kind != K_NOP);
          st       <= ST_FIN;
          case (op_kind)
            K_SHORT: if (cond_hit) st <= ST_RD_LO;
                     else pc_out <= pc_add(pc_in, 1);
            K_LBR:   if (cond_hit) st <= ST_RD_HI;
                     else pc_out <= pc_add(pc_in, 2);
            K_LSKP:  pc_out <= cond_hit ? pc_add(pc_in, 2) : pc_in;
            default: pc_out <= pc_in;
          endcase
        end
        ST_RD_HI: begin
          hi_lat <= rd_data[HI_W-1:0];
          st     <= ST_RD_LO;
        end
        ST_RD_LO: begin
          pc_out <= long_lat ? {hi_lat, rd_data} : {pc_lat[AW-1:DW], rd_data};
          st     <= ST_FIN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_req  = (st == ST_RD_HI) || (st == ST_RD_LO);
  assign rd_addr = (st == ST_RD_LO && long_lat) ? pc_add(pc_lat, 1) : pc_lat;
  assign done    = (st == ST_FIN);

  // Assertions
  a_r2_short_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
    (done && taken && kind_lat == K_SHORT) |-> (pc_out[AW-1:DW] == pc_lat[AW-1:DW]));
  a_r3_short_miss_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !taken && kind_lat == K_SHORT) |-> !$past(rd_req));
  a_r5_reads_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(rd_req)) |-> (rd_addr == $past(rd_addr) + AW'(1)));
  a_r7_skip_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind_lat inside {K_LSKP, K_NOP}) |-> !$past(rd_req));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_busy_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> $stable(pc_lat));
endmodule

// File: rtl/pc_redirect_unit.sv
module pc_redirect_unit
  import pcr_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_long,
  input  logic [3:0]        nib,
  input  logic [AW-1:0]     pc_in,
  input  logic              q_in,
  input  logic [DW-1:0]     d_in,
  input  logic              df_in,
  input  logic              ie_in,
  input  logic [FLAG_N-1:0] ef_n,
  input  logic [DW-1:0]     rd_data,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  output logic [AW-1:0]     pc_out,
  output logic              done,
  output logic              taken
);
  logic [FLAG_N-1:0] ef_seen_n;
  op_kind_e          op_kind;
  logic              cond_hit;

  flag_sync #(.WIDTH(FLAG_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ef_n), .sync_out(ef_seen_n));

  cond_eval #(.DW(DW)) u_cond (
    .is_long(is_long), .nib(nib), .q_in(q_in), .d_in(d_in), .df_in(df_in),
    .ie_in(ie_in), .ef_seen_n(ef_seen_n), .op_kind(op_kind), .cond_hit(cond_hit));

  redirect_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .is_long(is_long), .op_kind(op_kind),
    .cond_hit(cond_hit), .pc_in(pc_in), .rd_data(rd_data), .rd_req(rd_req),
    .rd_addr(rd_addr), .pc_out(pc_out), .done(done), .taken(taken));

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!done && !rd_req));
endmodule

// File: tb/pc_redirect_unit_tb.sv
module pc_redirect_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, start = 0, is_long = 0;
  logic [3:0]  nib = 0, ef_n = 4'hF;
  logic [15:0] pc_in = 0;
  logic        q_in = 0, df_in = 0, ie_in = 0;
  logic [7:0]  d_in = 0, rd_data;
  logic        rd_req, done, taken;
  logic [15:0] rd_addr, pc_out;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign rd_data = mem(rd_addr);

  pc_redirect_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_long(is_long), .nib(nib),
    .pc_in(pc_in), .q_in(q_in), .d_in(d_in), .df_in(df_in), .ie_in(ie_in),
    .ef_n(ef_n), .rd_data(rd_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .pc_out(pc_out), .done(done), .taken(taken));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: taken, next counter, number of reads.
  task automatic model(input bit lg, input logic [3:0] n, input logic [15:0] pc,
                       input bit q, input logic [7:0] d, input bit df, input bit ie,
                       input logic [3:0] efn, output bit tk, output logic [15:0] np,
                       output int nr);
    bit cset[8];
    cset = '{1'b1, q, d == 8'h00, df, !efn[0], !efn[1], !efn[2], !efn[3]};
    if (!lg) begin
      tk = (n < 8) ? cset[n] : !cset[n - 8];
      np = tk ? {pc[15:8], mem(pc)} : pc + 16'd1;
      nr = tk ? 1 : 0;
    end else if (n == 4) begin
      tk = 0; np = pc; nr = 0;
    end else if (n <= 3 || (n >= 9 && n <= 11)) begin
      tk = (n < 8) ? cset[n] : !cset[n - 8];
      np = tk ? {mem(pc), mem(pc + 16'd1)} : pc + 16'd2;
      nr = tk ? 2 : 0;
    end else begin
      case (n)
        5: tk = !q;  6: tk = d != 0;  7: tk = !df;  8: tk = 1;
        12: tk = ie; 13: tk = q;      14: tk = d == 0;
        default: tk = df;
      endcase
      np = tk ? pc + 16'd2 : pc;
      nr = 0;
    end
  endtask

  // settle: let flag pins pass the synchronizer before start.
  // busy_poke: keep start high with a junk counter while busy (R10).
  task automatic run_op(input bit lg, input logic [3:0] n, input logic [15:0] pc,
                        input bit q, input logic [7:0] d, input bit df, input bit ie,
                        input logic [3:0] efn, input logic [3:0] ef_model,
                        input bit settle, input bit busy_poke);
    bit tk; logic [15:0] np; int nr; string tag;
    @(negedge clk);
    ef_n = efn;
    if (settle) repeat (3) @(negedge clk);
    model(lg, n, pc, q, d, df, ie, ef_model, tk, np, nr);
    if (!lg) tag = tk ? "R2/R4" : "R3/R4";
    else if (n <= 3 || (n >= 9 && n <= 11)) tag = tk ? "R5/R6" : "R6";
    else tag = "R7";
    if (busy_poke) tag = {tag, "/R10"};
    is_long = lg; nib = n; pc_in = pc; q_in = q; d_in = d; df_in = df; ie_in = ie;
    start = 1;
    @(posedge clk); @(negedge clk);
    if (busy_poke) begin pc_in = ~pc; nib = ~n; end
    else start = 0;
    for (int i = 0; i < nr; i++) begin
      chk(rd_req === 1'b1, {tag, " rd_req"}, rd_req, 1);
      chk(rd_addr === (lg ? pc + 16'(i) : pc), {tag, " rd_addr"}, rd_addr, lg ? pc + 16'(i) : pc);
      chk(done === 1'b0, {tag, " early done"}, done, 0);
      @(posedge clk); @(negedge clk);
    end
    start = 0;
    chk(done === 1'b1, {tag, " done R9"}, done, 1);
    chk(rd_req === 1'b0, {tag, " rd_req at done"}, rd_req, 0);
    chk(pc_out === np, {tag, " pc_out"}, pc_out, np);
    chk(taken === tk, {tag, " taken"}, taken, tk);
    @(posedge clk); @(negedge clk);
    chk(done === 1'b0, "R9 done single", done, 0);
    chk(pc_out === np, "R9 pc_out hold", pc_out, np);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done === 0, "R1 done", done, 0);
    chk(rd_req === 0, "R1 rd_req", rd_req, 0);
    chk(taken === 0, "R1 taken", taken, 0);
    chk(pc_out === 0, "R1 pc_out", pc_out, 0);
    rst_n = 1;
    // R2/R3/R4 short branches
    run_op(0, 4'h0, 16'h1234, 0, 8'h11, 0, 0, 4'hF, 4'hF, 1, 0);
    run_op(0, 4'h8, 16'h1234, 0, 8'h11, 0, 0, 4'hF, 4'hF, 1, 0);
    run_op(0, 4'h1, 16'h2000, 1, 8'h11, 0, 0, 4'hF, 4'hF, 1, 0);
    run_op(0, 4'h9, 16'h2000, 1, 8'h11, 0, 0, 4'hF, 4'hF, 1, 0);
    run_op(0, 4'h2, 16'h30FE, 0, 8'h00, 0, 0, 4'hF, 4'hF, 1, 0);
    run_op(0, 4'hA, 16'h30FE, 0, 8'h00, 0, 0, 4'hF, 4'hF, 1, 0);
    run_op(0, 4'h3, 16'h4001, 0, 8'h01, 1, 0, 4'hF, 4'hF, 1, 0);
    run_op(0, 4'h5, 16'h5000, 0, 8'h01, 0, 0, 4'b1101, 4'b1101, 1, 0);
    run_op(0, 4'h4, 16'h5000, 0, 8'h01, 0, 0, 4'b1101, 4'b1101, 1, 0);
    run_op(0, 4'hD, 16'h5000, 0, 8'h01, 0, 0, 4'b1101, 4'b1101, 1, 0);
    run_op(0, 4'hF, 16'h5000, 0, 8'h01, 0, 0, 4'b0111, 4'b0111, 1, 0);
    // R8: pin change in the start cycle is not seen (model uses old level)
    run_op(0, 4'h4, 16'h6000, 0, 8'h01, 0, 0, 4'hF, 4'hF, 1, 0);
    run_op(0, 4'h4, 16'h6000, 0, 8'h01, 0, 0, 4'hE, 4'hF, 0, 0);
    // R5/R6 long branches
    run_op(1, 4'h0, 16'h4000, 0, 8'h22, 0, 0, 4'hF, 4'hF, 1, 0);
    run_op(1, 4'h1, 16'h4000, 0, 8'h22, 0, 0, 4'hF, 4'hF, 1, 0);
    run_op(1, 4'h9, 16'h4000, 0, 8'h22, 0, 0, 4'hF, 4'hF, 1, 0);
    run_op(1, 4'hA, 16'h7010, 0, 8'h22, 0, 0, 4'hF, 4'hF, 1, 0);
    run_op(1, 4'hB, 16'h7010, 0, 8'h22, 1, 0, 4'hF, 4'hF, 1, 0);
    // R7 long skips and no-op
    run_op(1, 4'h4, 16'h8000, 1, 8'h00, 1, 1, 4'hF, 4'hF, 1, 0);
    run_op(1, 4'h5, 16'h8000, 0, 8'h00, 1, 1, 4'hF, 4'hF, 1, 0);
    run_op(1, 4'h8, 16'h8000, 0, 8'h00, 1, 1, 4'hF, 4'hF, 1, 0);
    run_op(1, 4'hC, 16'h8000, 0, 8'h00, 1, 1, 4'hF, 4'hF, 1, 0);
    run_op(1, 4'hC, 16'h8000, 0, 8'h00, 1, 0, 4'hF, 4'hF, 1, 0);
    run_op(1, 4'h6, 16'h8000, 0, 8'h00, 1, 0, 4'hF, 4'hF, 1, 0);
    // R11 wrap-around
    run_op(1, 4'h8, 16'hFFFF, 0, 8'h00, 0, 0, 4'hF, 4'hF, 1, 0);
    run_op(1, 4'h0, 16'hFFFF, 0, 8'h00, 0, 0, 4'hF, 4'hF, 1, 0);
    run_op(0, 4'h8, 16'hFFFF, 0, 8'h00, 0, 0, 4'hF, 4'hF, 1, 0);
    // R10: start held with junk inputs during a long branch
    run_op(1, 4'h0, 16'h9ABC, 0, 8'h05, 0, 0, 4'hF, 4'hF, 1, 1);
    // Sweep every nibble in both groups with varied sources
    for (int k = 0; k < 64; k++) begin
      automatic logic [7:0] dv = (k % 3 == 0) ? 8'h00 : 8'(k * 37);
      automatic logic [3:0] ev = 4'(k * 5 + 3);
      run_op(k[5], 4'(k), 16'(k * 16'h0F13 + 16'h00F0), k[1], dv, k[2], k[3], ev, ev, 1, 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule